// File: doc/BRIEF.md
# Four-Phase Power-Up Sleep/Wake Sequencer

This block sequences a small processor into and out of its low-power states. The processor core offers a sleep request, which is either a wait-for-interrupt or a block instruction, together with the sleep depth that its configuration selects. The sequencer then decides how far to go. It can keep the main clock running, it can drop the enable of an external clock gate on the main clock, or it can also release a power-up request towards the system power controller. That release is one phase of a four-phase request/acknowledge handshake. The sequencer runs on an always-on clock that is never gated, so it can still see wake events while the main clock is stopped.

Wake-up comes from any interrupt line or, for a block request, from an unblock event. An unblock pulse that arrives while no block is waiting is remembered, and the next block request then completes at once. The sequencer also exposes a bus-access permission, which is low whenever the request or the synchronised acknowledge is low. It turns each executed unblock instruction into a one-cycle pulse for neighbouring cores. Sleep requests use a valid/ready pair. A request is taken only in a cycle where `slp_ready` is high, which is only while the processor is running. A request offered at any other time is dropped and has no effect, so the core must hold `slp_valid` until it sees ready.

Top module: `pwrup_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `pwr_req` and `clk_en` are 1 and `slp_ready` is 1. `wake_done` and `unblock_out` are 0, and `bus_ok` is 0 until the acknowledge has passed through the synchroniser.
- R2: Depth 0 accepts the request but keeps `clk_en` and `pwr_req` at 1. `slp_ready` is 0 until a wake event ends the wait.
- R3: Depth 1 drives `clk_en` to 0 from the cycle after acceptance until the wake cycle. `pwr_req` stays 1 throughout, so with `pwr_ack` tied to 1 the request never falls.
- R4: Depth 2 or 3 (bit 1 of `slp_depth` set) drives both `pwr_req` and `clk_en` to 0 from the cycle after acceptance. `pwr_req` rises again only after the synchronised acknowledge has been seen at 0 and a wake event has then been seen.
- R5: After `pwr_req` is reasserted, `clk_en` stays 0 until the synchronised acknowledge is seen at 1. In the following cycle `clk_en` is 1 and `wake_done` is 1 for one cycle.
- R6: `bus_ok` equals `pwr_req` AND the acknowledge delayed through a two-stage synchroniser clocked by `clk_ao`.
- R7: A wait-for-interrupt request (`slp_block`=0) wakes when any bit of `irq` is 1. A block request (`slp_block`=1) wakes when any `irq` bit is 1 or an unblock event occurs.
- R8: An `unblock_in` pulse that no waiting block consumes is remembered. The next block request then completes without sleeping: `wake_done` is 1 in the cycle after acceptance and `clk_en` stays 1.
- R9: A remembered unblock, or one arriving in the same cycle, is consumed by exactly one block completion. A second block request then sleeps.
- R10: `unblock_out` is 1 in the cycle after each cycle in which `unblock_exec` is 1, and 0 otherwise.
- R11: A sleep request offered while `slp_ready` is 0 is ignored and changes no output.
- R12: A request whose wake condition already holds in the accepting cycle completes at once. `wake_done` is 1 in the next cycle and `clk_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ao | input | 1 | Always-on clock, not gated |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised externally |
| slp_valid | input | 1 | Sleep request offered |
| slp_ready | output | 1 | Request taken this cycle (high only while running) |
| slp_block | input | 1 | 1 = block instruction, 0 = wait-for-interrupt |
| slp_depth | input | 2 | 0 clock on, 1 clock gated, 2/3 clock gated and power released |
| irq | input | NUM_IRQ | Level-sensitive interrupt lines, active high |
| unblock_in | input | 1 | Unblock event pulse from another core |
| unblock_exec | input | 1 | An unblock instruction executed this cycle |
| pwr_ack | input | 1 | Power-up acknowledge from the power controller (asynchronous) |
| pwr_req | output | 1 | Power-up request |
| clk_en | output | 1 | Enable for the external gate on the main clock |
| bus_ok | output | 1 | Bus access permitted |
| wake_done | output | 1 | One-cycle pulse when a sleep request completes |
| unblock_out | output | 1 | One-cycle pulse per executed unblock instruction |

## Verification
Two events that can meet in one cycle are the acceptance of a block request and an `unblock_in` pulse. The bench provokes this on purpose and again at random. The result is judged correct only if the block falls through and the event is not also left remembered for a later block. A second collision is a wake event that arrives while the request is still waiting for the acknowledge to fall. The bench raises an interrupt early in that window and checks that `pwr_req` stays low until the handshake has completed its low phase. Throughout the run, a cycle-level reference model in the bench predicts every output, with a power-controller model answering the request after random delays.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_HOLD_ON,
    ST_HOLD_GATED,
    ST_RELEASE,
    ST_OFF,
    ST_REQUEST
  } pstate_t;

  localparam int DEPTH_W = 2;

  function automatic logic depth_gates(input logic [DEPTH_W-1:0] d);
    return d != '0;
  endfunction

  function automatic logic depth_powers_down(input logic [DEPTH_W-1:0] d);
    return d[DEPTH_W-1];
  endfunction
endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 0) begin : g_bypass
      assign q = d;
    end else if (STAGES == 1) begin : g_one
      logic s;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s <= RESET_VAL;
        else        s <= d;
      end
      assign q = s;
    end else begin : g_chain
      logic [STAGES-1:0] s;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s <= {STAGES{RESET_VAL}};
        else        s <= {s[STAGES-2:0], d};
      end
      assign q = s[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pwrup_wake.sv
module pwrup_wake #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic               unblock_in,
  input  logic               consume,
  output logic               irq_any,
  output logic               unb_evt
);
  logic unb_latch;

  assign irq_any = |irq;
  assign unb_evt = unb_latch | unblock_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       unb_latch <= 1'b0;
    else if (consume) unb_latch <= 1'b0;
    else if (unblock_in) unb_latch <= 1'b1;
  end

  // R9: a consumed event is never left pending
  p_latch_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !unb_latch);

  // R8: an unconsumed unblock pulse is remembered
  p_latch_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unblock_in && !consume) |=> unb_latch);
endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
  import pwrup_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slp_valid,
  input  logic               slp_block,
  input  logic [DEPTH_W-1:0] slp_depth,
  input  logic               irq_any,
  input  logic               unb_evt,
  input  logic               ack_s,
  output logic               slp_ready,
  output logic               pwr_req,
  output logic               clk_en,
  output logic               wake_done,
  output logic               consume
);
  pstate_t st, st_nx;
  logic    pend_blk, pend_blk_nx;
  logic    done_nx;
  logic    blk_now, wake;

  assign blk_now = (st == ST_RUN) ? slp_block : pend_blk;
  assign wake    = irq_any | (blk_now & unb_evt);

  always_comb begin
    st_nx       = st;
    pend_blk_nx = pend_blk;
    done_nx     = 1'b0;
    consume     = 1'b0;
    unique case (st)
      ST_RUN: begin
        if (slp_valid) begin
          pend_blk_nx = slp_block;
          if (wake) begin
            done_nx = 1'b1;
            consume = slp_block;
          end else if (depth_powers_down(slp_depth)) begin
            st_nx = ST_RELEASE;
          end else if (depth_gates(slp_depth)) begin
            st_nx = ST_HOLD_GATED;
          end else begin
            st_nx = ST_HOLD_ON;
          end
        end
      end
      ST_HOLD_ON, ST_HOLD_GATED: begin
        if (wake) begin
          st_nx   = ST_RUN;
          done_nx = 1'b1;
          consume = pend_blk;
        end
      end
      ST_RELEASE: begin
        if (!ack_s) st_nx = ST_OFF;
      end
      ST_OFF: begin
        if (wake) begin
          st_nx   = ST_REQUEST;
          consume = pend_blk;
        end
      end
      ST_REQUEST: begin
        if (ack_s) begin
          st_nx   = ST_RUN;
          done_nx = 1'b1;
        end
      end
      default: st_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_RUN;
      pend_blk  <= 1'b0;
      wake_done <= 1'b0;
    end else begin
      st        <= st_nx;
      pend_blk  <= pend_blk_nx;
      wake_done <= done_nx;
    end
  end

  assign slp_ready = (st == ST_RUN);
  assign pwr_req   = (st != ST_RELEASE) && (st != ST_OFF);
  assign clk_en    = (st == ST_RUN) || (st == ST_HOLD_ON);

  // R4: request only rises after the acknowledge was seen low
  p_reassert_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_req) |-> $past(!ack_s));

  // R4: clock is never enabled while the request is released
  p_req_low_clk_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_req |-> !clk_en);

  // R5: completion is only signalled with the clock running
  p_done_with_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (clk_en && pwr_req));

  // R5: leaving the request phase needs a high acknowledge
  p_request_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REQUEST && !ack_s) |=> !clk_en);

  // R11: a request is taken only while running
  p_ready_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    slp_ready |-> (clk_en && pwr_req));
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int NUM_IRQ     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_ao,
  input  logic               rst_n,
  input  logic               slp_valid,
  output logic               slp_ready,
  input  logic               slp_block,
  input  logic [DEPTH_W-1:0] slp_depth,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic               unblock_in,
  input  logic               unblock_exec,
  input  logic               pwr_ack,
  output logic               pwr_req,
  output logic               clk_en,
  output logic               bus_ok,
  output logic               wake_done,
  output logic               unblock_out
);
  logic ack_s, irq_any, unb_evt, consume;

  pwrup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ack_sync (
    .clk(clk_ao), .rst_n(rst_n), .d(pwr_ack), .q(ack_s)
  );

  pwrup_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .clk(clk_ao), .rst_n(rst_n), .irq(irq), .unblock_in(unblock_in),
    .consume(consume), .irq_any(irq_any), .unb_evt(unb_evt)
  );

  pwrup_fsm u_fsm (
    .clk(clk_ao), .rst_n(rst_n), .slp_valid(slp_valid),
    .slp_block(slp_block), .slp_depth(slp_depth), .irq_any(irq_any),
    .unb_evt(unb_evt), .ack_s(ack_s), .slp_ready(slp_ready),
    .pwr_req(pwr_req), .clk_en(clk_en), .wake_done(wake_done),
    .consume(consume)
  );

  assign bus_ok = pwr_req & ack_s;

  always_ff @(posedge clk_ao or negedge rst_n) begin
    if (!rst_n) unblock_out <= 1'b0;
    else        unblock_out <= unblock_exec;
  end

  // R10: each executed unblock gives a pulse one cycle later
  p_unblock_pulse_r10: assert property (@(posedge clk_ao) disable iff (!rst_n)
    unblock_exec |=> unblock_out);

  // R6: bus access needs the request up
  p_bus_gate_r6: assert property (@(posedge clk_ao) disable iff (!rst_n)
    bus_ok |-> pwr_req);
endmodule

// File: tb/pwrup_seq_test.sv
module pwrup_seq_test;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slp_valid = 0, slp_block = 0;
  logic [1:0] slp_depth = 0;
  logic [NI-1:0] irq = '0;
  logic unblock_in = 0, unblock_exec = 0, pwr_ack = 1;
  logic slp_ready, pwr_req, clk_en, bus_ok, wake_done, unblock_out;

  int n_chk = 0, n_bad = 0, cyc = 0, seed_v;
  bit auto_pc = 0, cmp_en = 0, finished = 0;

  always #4 clk = ~clk;

  pwrup_seq #(.NUM_IRQ(NI), .SYNC_STAGES(2)) uut (
    .clk_ao(clk), .rst_n(rst_n), .slp_valid(slp_valid), .slp_ready(slp_ready),
    .slp_block(slp_block), .slp_depth(slp_depth), .irq(irq),
    .unblock_in(unblock_in), .unblock_exec(unblock_exec), .pwr_ack(pwr_ack),
    .pwr_req(pwr_req), .clk_en(clk_en), .bus_ok(bus_ok),
    .wake_done(wake_done), .unblock_out(unblock_out)
  );

  // reference model: 0 run,1 hold-on,2 hold-gated,3 release,4 off,5 request
  int m_st = 0;
  bit m_blk = 0, m_lat = 0, m_done = 0, m_ub = 0, m_a1 = 0, m_a2 = 0;

  function automatic bit e_req(int s);   return !(s == 3 || s == 4); endfunction
  function automatic bit e_clk(int s);   return (s == 0 || s == 1); endfunction
  function automatic bit e_ready(int s); return s == 0; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_blk = 0; m_lat = 0; m_done = 0; m_ub = 0; m_a1 = 0; m_a2 = 0;
    end else begin
      bit ev, blk, wk, cons, dn;
      int ns;
      ev = m_lat | unblock_in;
      blk = (m_st == 0) ? slp_block : m_blk;
      wk = (|irq) | (blk & ev);
      cons = 0; dn = 0; ns = m_st;
      case (m_st)
        0: if (slp_valid) begin
             m_blk = slp_block;
             if (wk) begin dn = 1; cons = slp_block; end
             else if (slp_depth[1]) ns = 3;
             else if (slp_depth != 0) ns = 2;
             else ns = 1;
           end
        1, 2: if (wk) begin ns = 0; dn = 1; cons = blk; end
        3: if (!m_a2) ns = 4;
        4: if (wk) begin ns = 5; cons = blk; end
        5: if (m_a2) begin ns = 0; dn = 1; end
        default: ns = 0;
      endcase
      m_lat = cons ? 1'b0 : ev;
      m_st = ns; m_done = dn; m_ub = unblock_exec;
      m_a2 = m_a1; m_a1 = pwr_ack;
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) if (cmp_en && rst_n) begin
    chk("R11 slp_ready model", slp_ready, e_ready(m_st));
    chk("R4 pwr_req model", pwr_req, e_req(m_st));
    chk("R3 clk_en model", clk_en, e_clk(m_st));
    chk("R6 bus_ok model", bus_ok, e_req(m_st) & m_a2);
    chk("R5 wake_done model", wake_done, m_done);
    chk("R10 unblock_out model", unblock_out, m_ub);
  end

  // power controller model: ack follows req after a random delay
  always @(posedge clk) begin
    cyc++;
    if (auto_pc) begin
      #1;
      if (pwr_ack != pwr_req && ($urandom % 3) == 0) pwr_ack = pwr_req;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) tick(); endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    seed_v = $urandom(32'h5EED1);
    ticks(3);
    // R1 reset state
    chk("R1 req in reset", pwr_req, 1); chk("R1 clk_en in reset", clk_en, 1);
    chk("R1 done in reset", wake_done, 0); chk("R1 bus_ok in reset", bus_ok, 0);
    rst_n = 1; cmp_en = 1;
    tick();
    chk("R1 ready after reset", slp_ready, 1);
    chk("R1 unblock_out after reset", unblock_out, 0);
    chk("R6 bus_ok before sync", bus_ok, 0);
    ticks(2);
    chk("R6 bus_ok after sync", bus_ok, 1);

    // R2 depth 0 wfi
    slp_valid = 1; slp_block = 0; slp_depth = 0; tick(); slp_valid = 0;
    chk("R2 clk on at depth0", clk_en, 1); chk("R2 not ready", slp_ready, 0);
    ticks(3); chk("R2 still waiting", wake_done, 0);
    irq = 4'b0100; tick(); irq = '0;
    chk("R7 wfi woken by irq", wake_done, 1); chk("R2 ready again", slp_ready, 1);
    tick(); chk("R5 done one cycle", wake_done, 0);

    // R8 remembered unblock, R9 consumed once
    unblock_in = 1; tick(); unblock_in = 0; ticks(2);
    slp_valid = 1; slp_block = 1; slp_depth = 1; tick();
    chk("R8 block falls through", wake_done, 1); chk("R8 clock kept", clk_en, 1);
    tick(); slp_valid = 0;
    chk("R9 second block sleeps", clk_en, 0); chk("R3 req held at depth1", pwr_req, 1);
    irq = '0; ticks(2); chk("R3 still gated", clk_en, 0);
    // R11 request while asleep is ignored
    slp_valid = 1; slp_depth = 2; tick(); slp_valid = 0;
    chk("R11 ignored request keeps req", pwr_req, 1);
    chk("R11 ignored request keeps gate", clk_en, 0);
    unblock_in = 1; tick(); unblock_in = 0;
    chk("R7 block woken by unblock", wake_done, 1); chk("R7 clock back", clk_en, 1);

    // R9 same-cycle unblock and block request
    unblock_in = 1; slp_valid = 1; slp_block = 1; slp_depth = 1; tick();
    unblock_in = 0; slp_valid = 0;
    chk("R9 same-cycle fall through", wake_done, 1);
    slp_valid = 1; tick(); slp_valid = 0;
    chk("R9 event not kept", clk_en, 0);
    irq = 4'b0001; tick(); irq = '0;
    chk("R7 block woken by irq", wake_done, 1);

    // R4/R5 deep sleep handshake, early wake
    slp_valid = 1; slp_block = 0; slp_depth = 2; tick(); slp_valid = 0;
    chk("R4 req released", pwr_req, 0); chk("R4 clk off", clk_en, 0);
    chk("R6 no bus when released", bus_ok, 0);
    irq = 4'b1000; ticks(3);
    chk("R4 waits for ack low", pwr_req, 0);
    pwr_ack = 0; ticks(3);
    chk("R4 still low while ack settles", pwr_req, 0);
    tick(); chk("R4 reasserted", pwr_req, 1); chk("R5 clk off during request", clk_en, 0);
    irq = '0;
    pwr_ack = 1; ticks(2); chk("R5 wait ack high", clk_en, 0);
    tick(); chk("R5 clk on", clk_en, 1); chk("R5 done pulse", wake_done, 1);
    chk("R6 bus ok after wake", bus_ok, 1);

    // R12 wake already pending
    irq = 4'b0010; slp_valid = 1; slp_depth = 1; tick(); slp_valid = 0; irq = '0;
    chk("R12 immediate done", wake_done, 1); chk("R12 clock kept", clk_en, 1);

    // R10 unblock pulses
    unblock_exec = 1; tick(); chk("R10 pulse", unblock_out, 1);
    unblock_exec = 0; tick(); chk("R10 pulse ends", unblock_out, 0);

    // ack tied high, shallow depths only: request never drops (R3)
    for (int i = 0; i < 1500; i++) begin
      slp_valid = ($urandom % 4) == 0; slp_block = $urandom; slp_depth = $urandom % 2;
      irq = (($urandom % 8) == 0) ? NI'($urandom) : '0;
      unblock_in = ($urandom % 9) == 0; unblock_exec = ($urandom % 6) == 0;
      tick();
      chk("R3 ack tied, req stays", pwr_req, 1);
    end

    // full random with power controller model
    auto_pc = 1;
    for (int i = 0; i < 6000; i++) begin
      slp_valid = ($urandom % 4) == 0; slp_block = $urandom; slp_depth = $urandom;
      irq = (($urandom % 10) == 0) ? NI'($urandom) : '0;
      unblock_in = ($urandom % 12) == 0; unblock_exec = ($urandom % 6) == 0;
      tick();
    end
    slp_valid = 0; irq = '0; unblock_in = 0; unblock_exec = 0;
    ticks(4);
    summary();
  end
endmodule